// File: doc/BRIEF.md
# Data Cache Store-Policy and Maintenance Controller

This block is a small direct-mapped data cache controller. Each access carries two region attribute bits: `req_cacheable` and `req_bufferable`. For a store, these bits select whether only the cache is written (write-back) or the cache and external memory are both written (write-through). Accesses whose cacheable bit is clear go straight to the external interfaces. The cache has no snoop port. Data shared with other masters must therefore be placed in non-cacheable regions.

The controller also performs three maintenance commands:
- Invalidate the whole cache in one step, discarding dirty data.
- Invalidate one addressed line, discarding its dirty data.
- Clean one addressed line. A dirty line is copied out through the write-buffer handshake, and the line then stays valid with its dirty bit cleared.

A cacheable load that misses refills the line through a read handshake. If the victim line is dirty, it is written back first. A store miss never allocates a line. While `busy` is high, requests are not accepted.

Top module: `dcache_wpol_ctrl`

## Requirements
- R1: After reset, `busy`, `wb_valid`, `rd_valid` and `rsp_valid` are 0 and every line is invalid.
- R2: A store with cacheable=1 and bufferable=1 that hits updates the cached word and marks the line dirty. It issues no external write and leaves `busy` low.
- R3: A store with cacheable=1 and bufferable=0 that hits updates the cached word and issues exactly one write-buffer transfer with the store's address and data. It never sets the dirty bit.
- R4: With cacheable=0, a load makes exactly one external read and returns its data, and a store makes exactly one external write. The cache contents are left unchanged.
- R5: A store miss in a cacheable region is forwarded as one external write. No line is allocated or modified.
- R6: A cacheable load miss refills the line with 4 reads at line base +0, +4, +8, +12, in that order, and returns the requested word. If the victim line is valid and dirty, its 4 words are written back first, in the same order.
- R7: `req_op`=2 (flush all) holds `busy` for exactly one cycle. Afterwards every line is invalid, and no dirty data is written out.
- R8: `req_op`=3 (flush line) invalidates the addressed line if it hits, with no write-back. Other lines are untouched.
- R9: `req_op`=4 (clean line) on a dirty hit writes the line's 4 words through the write buffer at base +0, +4, +8, +12. The line then stays valid and is clean.
- R10: Cleaning a line that is clean or absent causes no external write.
- R11: While `busy` is high, requests are ignored. A pending `wb_valid` or `rd_valid` keeps its address (and its data, for writes) stable until the matching ready is seen.
- R12: A cacheable load hit (`req_op`=0) raises `rsp_valid` with the cached word in the cycle after acceptance, with no external read.

Store is `req_op`=1. Address bits [3:2] select the word, bits [7:4] select the line, and bits [31:8] form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 3 | 0 load, 1 store, 2 flush all, 3 flush line, 4 clean line |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_cacheable | input | 1 | Region cacheable attribute |
| req_bufferable | input | 1 | Region bufferable attribute |
| busy | output | 1 | Controller occupied; new requests stall |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_data | output | 32 | Load data |
| wb_valid | output | 1 | Write-buffer transfer request |
| wb_addr | output | 32 | Write-buffer address |
| wb_data | output | 32 | Write-buffer data |
| wb_ready | input | 1 | Write buffer accepts the transfer |
| rd_valid | output | 1 | External read request |
| rd_addr | output | 32 | External read address |
| rd_ready | input | 1 | Read data present on `rd_data` |
| rd_data | input | 32 | External read data |

## Verification
The assertions check, on every cycle, the following properties:
- Handshake stability toward the write buffer and the read port.
- The quiet result of a write-back hit and the single transfer of a write-through hit.
- The one-cycle flush-all occupancy and the clearing of all line state.
- The next-cycle response of a load hit.
- The rule that no line is ever dirty without being valid.

Other behaviour appears only across sequences of requests, so only the bench scenarios can show it:
- Dirtiness becomes visible only when a later clean or eviction writes data out.
- A missed store or an uncacheable store must leave the cached data unchanged.
- A flushed line must refill rather than hit.
- Requests offered during a refill must be ignored.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [2:0] {
        OP_LOAD       = 3'd0,
        OP_STORE      = 3'd1,
        OP_FLUSH_ALL  = 3'd2,
        OP_FLUSH_LINE = 3'd3,
        OP_CLEAN      = 3'd4
    } dc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT_WR,
        ST_EXT_RD,
        ST_EVICT,
        ST_FILL,
        ST_FLUSH
    } dc_state_e;

endpackage

// File: rtl/dcw_tag_store.sv
module dcw_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_vdirty,
    output logic [TAG_W-1:0] lk_tag_rd,
    input  logic             flush_all,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_valid,
    input  logic             upd_dirty
);

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0]            dirty;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } tstore_s;

    tstore_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush_all) begin
            s_d.valid = '0;
            s_d.dirty = '0;
        end else if (upd_en) begin
            s_d.valid[upd_idx] = upd_valid;
            s_d.dirty[upd_idx] = upd_dirty;
            s_d.tag[upd_idx]   = upd_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lk_tag_rd = s_q.tag[lk_idx];
    assign lk_hit    = s_q.valid[lk_idx] && (s_q.tag[lk_idx] == lk_tag);
    assign lk_vdirty = s_q.valid[lk_idx] && s_q.dirty[lk_idx];

    // R7: a whole-cache flush leaves no valid or dirty line behind
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (s_q.valid == '0) && (s_q.dirty == '0));

    // R2: dirtiness is only ever recorded on a valid line
    p_dirty_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.dirty & ~s_q.valid) == '0);

endmodule

// File: rtl/dcw_data_store.sv
module dcw_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int WRD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WRD_W-1:0]  wr_wrd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WRD_W-1:0]  rd_wrd,
    output logic [DATA_W-1:0] rd_data
);

    logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_idx][wr_wrd] = wr_data;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx][rd_wrd];

endmodule

// File: rtl/dcache_wpol_ctrl.sv
module dcache_wpol_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_cacheable,
    input  logic              req_bufferable,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data
);
    import dcw_pkg::*;

    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int WRD_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - WRD_W - OFF_W;
    localparam logic [WRD_W-1:0] LAST_WRD = WRD_W'(WORDS - 1);

    typedef struct packed {
        dc_state_e         state;
        logic [IDX_W-1:0]  idx;
        logic [WRD_W-1:0]  wrd;
        logic [WRD_W-1:0]  cnt;
        logic [TAG_W-1:0]  ltag;
        logic [TAG_W-1:0]  ntag;
        logic              fill;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } ctrl_s;

    ctrl_s c_d, c_q;

    dc_op_e            op_e;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WRD_W-1:0]  req_wrd;
    logic              idle, accept;

    logic              lk_hit, lk_vdirty;
    logic [TAG_W-1:0]  lk_tag_rd;
    logic              t_flush, t_upd, t_valid, t_dirty;
    logic [IDX_W-1:0]  t_idx;
    logic [TAG_W-1:0]  t_tag;
    logic              d_wr;
    logic [IDX_W-1:0]  d_idx, d_ridx;
    logic [WRD_W-1:0]  d_wrd, d_rwrd;
    logic [DATA_W-1:0] d_data, d_rdata;

    assign op_e    = dc_op_e'(req_op);
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = req_addr[OFF_W+WRD_W +: IDX_W];
    assign req_wrd = req_addr[OFF_W +: WRD_W];
    assign idle    = (c_q.state == ST_IDLE);
    assign accept  = req_valid && idle;

    dcw_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_idx), .lk_tag(req_tag),
        .lk_hit(lk_hit), .lk_vdirty(lk_vdirty), .lk_tag_rd(lk_tag_rd),
        .flush_all(t_flush), .upd_en(t_upd), .upd_idx(t_idx),
        .upd_tag(t_tag), .upd_valid(t_valid), .upd_dirty(t_dirty)
    );

    assign d_ridx = idle ? req_idx : c_q.idx;
    assign d_rwrd = idle ? req_wrd : c_q.cnt;

    dcw_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) data_i (
        .clk(clk), .wr_en(d_wr), .wr_idx(d_idx), .wr_wrd(d_wrd), .wr_data(d_data),
        .rd_idx(d_ridx), .rd_wrd(d_rwrd), .rd_data(d_rdata)
    );

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        t_flush = 1'b0; t_upd = 1'b0; t_valid = 1'b0; t_dirty = 1'b0;
        t_idx   = c_q.idx; t_tag = c_q.ltag;
        d_wr    = 1'b0; d_idx = c_q.idx; d_wrd = c_q.cnt; d_data = rd_data;
        unique case (c_q.state)
            ST_IDLE: if (req_valid) begin
                c_d.idx   = req_idx;
                c_d.wrd   = req_wrd;
                c_d.addr  = req_addr;
                c_d.wdata = req_wdata;
                c_d.cnt   = '0;
                unique case (op_e)
                    OP_LOAD: begin
                        if (!req_cacheable) begin
                            c_d.state = ST_EXT_RD;
                        end else if (lk_hit) begin
                            c_d.rsp_valid = 1'b1;
                            c_d.rsp_data  = d_rdata;
                        end else begin
                            c_d.ntag  = req_tag;
                            c_d.ltag  = lk_tag_rd;
                            c_d.fill  = 1'b1;
                            c_d.state = lk_vdirty ? ST_EVICT : ST_FILL;
                        end
                    end
                    OP_STORE: begin
                        if (req_cacheable && lk_hit) begin
                            d_wr = 1'b1; d_idx = req_idx; d_wrd = req_wrd; d_data = req_wdata;
                            if (req_bufferable) begin
                                t_upd = 1'b1; t_idx = req_idx; t_tag = req_tag;
                                t_valid = 1'b1; t_dirty = 1'b1;
                            end else begin
                                c_d.state = ST_EXT_WR;
                            end
                        end else begin
                            c_d.state = ST_EXT_WR;
                        end
                    end
                    OP_FLUSH_ALL: c_d.state = ST_FLUSH;
                    OP_FLUSH_LINE: if (lk_hit) begin
                        t_upd = 1'b1; t_idx = req_idx; t_tag = req_tag;
                    end
                    OP_CLEAN: if (lk_hit && lk_vdirty) begin
                        c_d.ltag  = req_tag;
                        c_d.fill  = 1'b0;
                        c_d.state = ST_EVICT;
                    end
                    default: ;
                endcase
            end
            ST_EXT_WR: if (wb_ready) c_d.state = ST_IDLE;
            ST_EXT_RD: if (rd_ready) begin
                c_d.rsp_valid = 1'b1;
                c_d.rsp_data  = rd_data;
                c_d.state     = ST_IDLE;
            end
            ST_EVICT: if (wb_ready) begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == LAST_WRD) begin
                    c_d.cnt = '0;
                    if (c_q.fill) begin
                        c_d.state = ST_FILL;
                    end else begin
                        t_upd = 1'b1; t_valid = 1'b1;
                        c_d.state = ST_IDLE;
                    end
                end
            end
            ST_FILL: if (rd_ready) begin
                d_wr    = 1'b1;
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt == c_q.wrd) c_d.rsp_data = rd_data;
                if (c_q.cnt == LAST_WRD) begin
                    c_d.cnt = '0;
                    t_upd = 1'b1; t_tag = c_q.ntag; t_valid = 1'b1;
                    c_d.rsp_valid = 1'b1;
                    c_d.state     = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                t_flush   = 1'b1;
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy      = !idle;
    assign rsp_valid = c_q.rsp_valid;
    assign rsp_data  = c_q.rsp_data;
    assign wb_valid  = (c_q.state == ST_EXT_WR) || (c_q.state == ST_EVICT);
    assign wb_addr   = (c_q.state == ST_EXT_WR) ? c_q.addr
                     : {c_q.ltag, c_q.idx, c_q.cnt, {OFF_W{1'b0}}};
    assign wb_data   = (c_q.state == ST_EXT_WR) ? c_q.wdata : d_rdata;
    assign rd_valid  = (c_q.state == ST_EXT_RD) || (c_q.state == ST_FILL);
    assign rd_addr   = (c_q.state == ST_EXT_RD) ? c_q.addr
                     : {c_q.ntag, c_q.idx, c_q.cnt, {OFF_W{1'b0}}};

    // R11: a write-buffer request waits unchanged for its ready
    p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

    // R11: a read request waits unchanged for its ready
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));

    // R2: write-back hit stays inside the cache
    p_wbhit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e == OP_STORE && req_cacheable && req_bufferable && lk_hit)
        |=> !wb_valid && !busy);

    // R3: write-through hit forwards the same address and data
    p_wthit_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e == OP_STORE && req_cacheable && !req_bufferable && lk_hit)
        |=> wb_valid && wb_addr == $past(req_addr) && wb_data == $past(req_wdata));

    // R7: flush-all occupies the controller for exactly one cycle
    p_flushall_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e == OP_FLUSH_ALL) |=> busy && !wb_valid && !rd_valid ##1 !busy);

    // R12: load hit answers in the next cycle without external traffic
    p_loadhit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e == OP_LOAD && req_cacheable && lk_hit) |=> rsp_valid && !busy && !rd_valid);

endmodule

// File: tb/dcache_wpol_ctrl_tb_top.sv
module dcache_wpol_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_cacheable = 1'b0, req_bufferable = 1'b0;
    logic        busy, rsp_valid, wb_valid, rd_valid;
    logic [31:0] rsp_data, wb_addr, wb_data, rd_addr;
    logic        wb_ready = 1'b0, rd_ready = 1'b0;
    logic [31:0] rd_data = '0;

    int checks = 0, failures = 0;
    int wr_cnt = 0, rd_cnt = 0, cyc = 0;
    logic [31:0] wlog_a [4];
    logic [31:0] wlog_d [4];
    logic        got_rsp;
    logic [31:0] got_data;
    int          busy_cyc;
    bit          done = 0;

    always #5 clk = ~clk;

    dcache_wpol_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
        .req_bufferable(req_bufferable), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .wb_ready(wb_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // External memory model: stalls on a fixed pattern, logs handshakes due at the next edge
    initial forever begin
        @(negedge clk);
        cyc++;
        wb_ready = (cyc % 3) != 0;
        rd_ready = (cyc % 4) != 1;
        rd_data  = mem_word(rd_addr);
        if (rst_n && wb_valid && wb_ready) begin
            wlog_a[wr_cnt % 4] = wb_addr;
            wlog_d[wr_cnt % 4] = wb_data;
            wr_cnt++;
        end
        if (rst_n && rd_valid && rd_ready) rd_cnt++;
    end

    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                         input logic c, input logic b);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        req_cacheable = c; req_bufferable = b;
        @(negedge clk);
        req_valid = 1'b0;
        got_rsp = 1'b0; got_data = '0; busy_cyc = 0;
        forever begin
            if (rsp_valid) begin got_rsp = 1'b1; got_data = rsp_data; end
            if (!busy) break;
            busy_cyc++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        c;
        logic        b;
        logic [3:0]  exp_wr;
        logic [3:0]  exp_rd;
        logic        exp_rsp;
        logic [31:0] exp_data;
        logic [31:0] exp_waddr;
        logic [31:0] exp_wdata;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 32'h100, 32'h0, 1, 1, 4'd0, 4'd4, 1, 32'hC0DE0100, 32'h0, 32'h0, 8'd6},         // R6 fill
        '{3'd0, 32'h108, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'hC0DE0108, 32'h0, 32'h0, 8'd12},        // R12 hit
        '{3'd1, 32'h104, 32'h11111111, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd2},         // R2
        '{3'd0, 32'h104, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'h11111111, 32'h0, 32'h0, 8'd2},         // R2
        '{3'd1, 32'h10C, 32'h00002222, 1, 0, 4'd1, 4'd0, 0, 32'h0, 32'h10C, 32'h2222, 8'd3},    // R3
        '{3'd0, 32'h10C, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'h00002222, 32'h0, 32'h0, 8'd3},         // R3
        '{3'd4, 32'h100, 32'h0, 1, 1, 4'd4, 4'd0, 0, 32'h0, 32'h10C, 32'h2222, 8'd9},           // R9
        '{3'd4, 32'h100, 32'h0, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd10},               // R10
        '{3'd0, 32'h104, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'h11111111, 32'h0, 32'h0, 8'd9},         // R9 stays valid
        '{3'd1, 32'h20C, 32'h77777777, 1, 1, 4'd1, 4'd0, 0, 32'h0, 32'h20C, 32'h77777777, 8'd5},// R5
        '{3'd0, 32'h104, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'h11111111, 32'h0, 32'h0, 8'd5},         // R5 unchanged
        '{3'd1, 32'h108, 32'h33333333, 0, 1, 4'd1, 4'd0, 0, 32'h0, 32'h108, 32'h33333333, 8'd4},// R4
        '{3'd0, 32'h108, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'hC0DE0108, 32'h0, 32'h0, 8'd4},         // R4 unchanged
        '{3'd0, 32'h108, 32'h0, 0, 0, 4'd0, 4'd1, 1, 32'hC0DE0108, 32'h0, 32'h0, 8'd4},         // R4 load
        '{3'd1, 32'h108, 32'h44444444, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd2},         // R2
        '{3'd0, 32'h208, 32'h0, 1, 1, 4'd4, 4'd4, 1, 32'hC0DE0208, 32'h10C, 32'h2222, 8'd6},    // R6 evict
        '{3'd0, 32'h108, 32'h0, 1, 1, 4'd0, 4'd4, 1, 32'hC0DE0108, 32'h0, 32'h0, 8'd6},         // R6
        '{3'd0, 32'h110, 32'h0, 1, 1, 4'd0, 4'd4, 1, 32'hC0DE0110, 32'h0, 32'h0, 8'd6},         // R6
        '{3'd1, 32'h118, 32'h55555555, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd2},         // R2
        '{3'd3, 32'h110, 32'h0, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd8},                // R8
        '{3'd0, 32'h118, 32'h0, 1, 1, 4'd0, 4'd4, 1, 32'hC0DE0118, 32'h0, 32'h0, 8'd8},         // R8 refetch
        '{3'd0, 32'h104, 32'h0, 1, 1, 4'd0, 4'd0, 1, 32'hC0DE0104, 32'h0, 32'h0, 8'd8},         // R8 others kept
        '{3'd1, 32'h104, 32'h66666666, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd2},         // R2
        '{3'd2, 32'h0, 32'h0, 1, 1, 4'd0, 4'd0, 0, 32'h0, 32'h0, 32'h0, 8'd7},                  // R7
        '{3'd0, 32'h104, 32'h0, 1, 1, 4'd0, 4'd4, 1, 32'hC0DE0104, 32'h0, 32'h0, 8'd7},         // R7
        '{3'd0, 32'h118, 32'h0, 1, 1, 4'd0, 4'd4, 1, 32'hC0DE0118, 32'h0, 32'h0, 8'd7}          // R7
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !wb_valid && !rd_valid && !rsp_valid, "R1", "outputs idle in reset",
            {busy, wb_valid, rd_valid, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1", "busy after reset", busy, 0);

        for (int i = 0; i < NV; i++) begin
            automatic int w0 = wr_cnt;
            automatic int r0 = rd_cnt;
            automatic string tag = $sformatf("R%0d", VEC[i].req);
            do_op(VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].c, VEC[i].b);
            chk(wr_cnt - w0 == VEC[i].exp_wr, tag, $sformatf("vec %0d write count", i),
                wr_cnt - w0, VEC[i].exp_wr);
            chk(rd_cnt - r0 == VEC[i].exp_rd, tag, $sformatf("vec %0d read count", i),
                rd_cnt - r0, VEC[i].exp_rd);
            chk(got_rsp == VEC[i].exp_rsp, tag, $sformatf("vec %0d response flag", i),
                got_rsp, VEC[i].exp_rsp);
            if (VEC[i].exp_rsp)
                chk(got_data == VEC[i].exp_data, tag, $sformatf("vec %0d load data", i),
                    got_data, VEC[i].exp_data);
            if (VEC[i].exp_wr != 0) begin
                chk(wlog_a[(wr_cnt - 1) % 4] == VEC[i].exp_waddr, tag,
                    $sformatf("vec %0d last write addr", i), wlog_a[(wr_cnt - 1) % 4], VEC[i].exp_waddr);
                chk(wlog_d[(wr_cnt - 1) % 4] == VEC[i].exp_wdata, tag,
                    $sformatf("vec %0d last write data", i), wlog_d[(wr_cnt - 1) % 4], VEC[i].exp_wdata);
            end
            if (VEC[i].op == 3'd2)
                chk(busy_cyc == 1, "R7", "flush-all busy cycles", busy_cyc, 1);
            if (VEC[i].op == 3'd0 && VEC[i].exp_rd == 0 && VEC[i].c)
                chk(busy_cyc == 0, "R12", "load hit latency", busy_cyc, 0);
        end

        // R9: clean writes the four words in order from the line base
        do_op(3'd0, 32'h420, 32'h0, 1, 1);
        do_op(3'd1, 32'h424, 32'h99999999, 1, 1);
        begin
            automatic int w0 = wr_cnt;
            do_op(3'd4, 32'h428, 32'h0, 1, 1);
            chk(wr_cnt - w0 == 4, "R9", "clean beat count", wr_cnt - w0, 4);
            for (int k = 0; k < 4; k++)
                chk(wlog_a[(w0 + k) % 4] == 32'h420 + 32'(4 * k), "R9", "clean beat address",
                    wlog_a[(w0 + k) % 4], 32'h420 + 32'(4 * k));
            chk(wlog_d[(w0 + 1) % 4] == 32'h99999999, "R9", "clean dirty word data",
                wlog_d[(w0 + 1) % 4], 32'h99999999);
            chk(wlog_d[(w0 + 2) % 4] == mem_word(32'h428), "R9", "clean filled word data",
                wlog_d[(w0 + 2) % 4], mem_word(32'h428));
        end

        // R11: a request offered while busy is ignored
        begin
            automatic int w0 = wr_cnt;
            automatic int r0 = rd_cnt;
            while (busy) @(negedge clk);
            req_valid = 1'b1; req_op = 3'd0; req_addr = 32'h834; req_cacheable = 1; req_bufferable = 1;
            @(negedge clk);
            chk(busy, "R11", "refill started", busy, 1);
            req_op = 3'd1; req_addr = 32'h900; req_wdata = 32'hDEADBEEF; req_cacheable = 0;
            @(negedge clk);
            req_valid = 1'b0;
            while (busy) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(wr_cnt == w0, "R11", "store during busy ignored", wr_cnt - w0, 0);
            chk(rd_cnt - r0 == 4, "R11", "only the refill reads", rd_cnt - r0, 4);
            do_op(3'd0, 32'h83C, 32'h0, 1, 1);
            chk(got_rsp && got_data == mem_word(32'h83C), "R12", "hit after refill",
                got_data, mem_word(32'h83C));
        end

        // R10: clean of an absent line
        begin
            automatic int w0 = wr_cnt;
            do_op(3'd4, 32'hA40, 32'h0, 1, 1);
            chk(wr_cnt == w0, "R10", "clean of absent line", wr_cnt - w0, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule